// File: doc/BRIEF.md
# Calendar Real-Time Clock

This block keeps wall-clock time and calendar date in two packed 32-bit counter words: one for day-of-month, hours, minutes and seconds, and one for century, two-digit year and month. Software reaches it over a small single-cycle register bus. Writes take effect on the clock edge. Reads are combinational from the current address. A one-cycle `tick_1hz` strobe, made elsewhere, moves the time forward by one second while the clock is enabled. The calendar carries through minutes, hours, days of the right month length (leap Februaries included), months, years and centuries.

A control register holds two bits: a run bit that lets ticks advance the clock, and a guard bit that must be set before either counter word can be written. Two further word addresses, an alarm word and an alarm status word, are decoded but do nothing. The interrupt output stays low.

Top module: `rtc_calendar`

## Requirements
- R1: After reset every readable word (time, date, control, alarm, alarm status) reads as zero.
- R2: The time word carries day-of-month in bits 28:24, hours in 20:16, minutes in 13:8 and seconds in 5:0. The date word carries century in bits 20:16, year-in-century in 14:8 and month (1 = January) in 3:0. An accepted write replaces the whole word, and all other bits read as zero.
- R3: The control word sits at byte offset 0x10. Bit 0 is run and bit 1 is write-guard release. A write to it is always accepted, and it reads back bits 1:0 with zeros above.
- R4: A write to the time word (offset 0x00) or the date word (offset 0x04) is dropped unless control bit 1 is set.
- R5: Offsets 0x08 and 0x14, and any other offset that is not mapped, read as zero, and writes to them change nothing. `irq_o` is always 0.
- R6: When run is set and `tick_1hz` is high, the time advances by exactly one second. Otherwise both counter words hold their value.
- R7: Seconds and minutes wrap from 59 to 0 and carry. Hours wrap from 23 to 0 and carry into the day.
- R8: The day wraps to 1 after day 31 in months 1, 3, 5, 7, 8, 10 and 12, after day 30 in months 4, 6, 9 and 11, and after day 28 or 29 in month 2. Each wrap carries into the month.
- R9: February has 29 days when the full year (century*100 + year) is divisible by 4 and not by 100, or is divisible by 400. Otherwise it has 28.
- R10: The month wraps from 12 to 1 and increments the year. The year wraps from 99 to 0 and increments the century.
- R11: If an accepted counter write and a tick land in the same cycle, the written word is stored, the other counter word is left alone, and that tick is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | ADDR_W (5) | Byte offset; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Interrupt, held at 0 |

## Verification
The bench sweeps every month of years that test each branch of the leap rule: 1900, 2000, 2100, 2400, 2023, 2024, and 1999 for the century carry. It puts the clock one second before midnight on the last day of the month and on the day before that, then compares the result with a calendar computed arithmetically in the bench. A design that tested only divisibility by 4 would give 1900 and 2100 a 29th of February. A design that treated every century year as common would skip 29 February 2000 and 2400. A full walk through 2024 day by day catches any wrong month length. A wrong month or year carry would show up as 13 months or as year 100. Writes with the guard closed, writes colliding with a tick, and the dead alarm offsets are each checked through the read port. A design that let a tick slip past a write, or stored stray bits, would read back a different word.

// File: rtl/rtc_cal_pkg.sv
// Package: shared field types, word packing and address map for the calendar clock.
// Assumes the fixed packed layouts listed in the brief.
package rtc_cal_pkg;

    typedef struct packed {
        logic [4:0] day;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } rtc_time_t;

    typedef struct packed {
        logic [4:0] cent;
        logic [6:0] year;
        logic [3:0] month;
    } rtc_date_t;

    // Word indices (byte offset / 4); the layout is software visible
    localparam int WIDX_TIME  = 0;
    localparam int WIDX_DATE  = 1;
    localparam int WIDX_ALARM = 2;
    localparam int WIDX_CTRL  = 4;
    localparam int WIDX_ASTAT = 5;

    // Last legal value of each wrapping field
    localparam logic [5:0] SEC_LAST   = 6'd59;
    localparam logic [5:0] MIN_LAST   = 6'd59;
    localparam logic [4:0] HOUR_LAST  = 5'd23;
    localparam logic [3:0] MONTH_LAST = 4'd12;
    localparam logic [6:0] YEAR_LAST  = 7'd99;

    function automatic logic [31:0] time_to_word(rtc_time_t t);
        return {3'b0, t.day, 3'b0, t.hour, 2'b0, t.min, 2'b0, t.sec};
    endfunction

    function automatic logic [31:0] date_to_word(rtc_date_t d);
        return {11'b0, d.cent, 1'b0, d.year, 4'b0, d.month};
    endfunction

    function automatic rtc_time_t word_to_time(logic [31:0] w);
        return '{day: w[28:24], hour: w[20:16], min: w[13:8], sec: w[5:0]};
    endfunction

    function automatic rtc_date_t word_to_date(logic [31:0] w);
        return '{cent: w[20:16], year: w[14:8], month: w[3:0]};
    endfunction

endpackage

// File: rtl/rtc_cal_wrap.sv
// Module: one wrapping calendar field with carry in and carry out.
// Steps only when carry_in is set. A value at or above `last` goes back to `first`
// and raises carry_out, so out-of-range written values recover on the next step.
module rtc_cal_wrap #(
    parameter int W = 6
) (
    input  logic [W-1:0] val,
    input  logic [W-1:0] last,
    input  logic [W-1:0] first,
    input  logic         carry_in,
    output logic [W-1:0] nxt,
    output logic         carry_out
);
    logic at_end;

    // Decide whether this field wraps and what its next value is
    always_comb begin
        at_end    = (val >= last);
        carry_out = carry_in && at_end;
        if (!carry_in)   nxt = val;
        else if (at_end) nxt = first;
        else             nxt = val + W'(1);
    end
endmodule

// File: rtl/rtc_cal_monthlen.sv
// Module: number of days in the current month, leap years included.
// Because the full year is century*100 + year, a year-in-century of zero is a leap
// year only when the century is a multiple of 4. Any other year is a leap year when
// it is a multiple of 4. Month codes outside 1..12 are treated as 31-day months.
module rtc_cal_monthlen (
    input  logic [3:0] month,
    input  logic [6:0] year,
    input  logic [4:0] cent,
    output logic [4:0] days
);
    logic leap;

    // Leap decision followed by a month-length lookup
    always_comb begin
        leap = (year == 7'd0) ? (cent[1:0] == 2'd0) : (year[1:0] == 2'd0);
        case (month)
            4'd2:                       days = leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:    days = 5'd30;
            default:                    days = 5'd31;
        endcase
    end
endmodule

// File: rtl/rtc_cal_advance.sv
// Module: combinational "plus one second" over the whole packed calendar.
// Produces the next time and date when step is high, and the inputs unchanged otherwise.
module rtc_cal_advance
    import rtc_cal_pkg::*;
(
    input  rtc_time_t cur_t,
    input  rtc_date_t cur_d,
    input  logic      step,
    output rtc_time_t nxt_t,
    output rtc_date_t nxt_d
);
    logic       c_sec, c_min, c_hour, c_day, c_month, c_year;
    logic [4:0] month_days;

    rtc_cal_monthlen len_i (
        .month(cur_d.month), .year(cur_d.year), .cent(cur_d.cent), .days(month_days)
    );

    rtc_cal_wrap #(.W(6)) sec_i (
        .val(cur_t.sec), .last(SEC_LAST), .first(6'd0), .carry_in(step),
        .nxt(nxt_t.sec), .carry_out(c_sec)
    );
    rtc_cal_wrap #(.W(6)) min_i (
        .val(cur_t.min), .last(MIN_LAST), .first(6'd0), .carry_in(c_sec),
        .nxt(nxt_t.min), .carry_out(c_min)
    );
    rtc_cal_wrap #(.W(5)) hour_i (
        .val(cur_t.hour), .last(HOUR_LAST), .first(5'd0), .carry_in(c_min),
        .nxt(nxt_t.hour), .carry_out(c_hour)
    );
    rtc_cal_wrap #(.W(5)) day_i (
        .val(cur_t.day), .last(month_days), .first(5'd1), .carry_in(c_hour),
        .nxt(nxt_t.day), .carry_out(c_day)
    );
    rtc_cal_wrap #(.W(4)) month_i (
        .val(cur_d.month), .last(MONTH_LAST), .first(4'd1), .carry_in(c_day),
        .nxt(nxt_d.month), .carry_out(c_month)
    );
    rtc_cal_wrap #(.W(7)) year_i (
        .val(cur_d.year), .last(YEAR_LAST), .first(7'd0), .carry_in(c_month),
        .nxt(nxt_d.year), .carry_out(c_year)
    );

    // Century is a plain 5-bit counter fed by the year carry
    always_comb nxt_d.cent = cur_d.cent + {4'd0, c_year};
endmodule

// File: rtl/rtc_calendar.sv
// Module: calendar real-time clock with a 32-bit register bus.
// Assumes tick_1hz is a single-cycle strobe in the clk domain and that the bus is
// single-cycle: writes are taken on the edge, reads are combinational.
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] widx;
    logic             unused_lsb;
    logic [1:0]       ctrl_q;
    logic             run_en, wr_open;
    logic             wr_time, wr_date, cnt_wr, step;
    rtc_time_t        time_q, time_nx;
    rtc_date_t        date_q, date_nx;
    logic [31:0]      time_word, date_word;

    assign widx       = bus_addr[ADDR_W-1:2];
    assign unused_lsb = ^bus_addr[1:0];
    assign run_en     = ctrl_q[0];
    assign wr_open    = ctrl_q[1];
    assign irq_o      = 1'b0;

    // Counter-write qualification and tick gating (a write swallows the tick)
    always_comb begin
        wr_time = bus_wr && wr_open && (widx == IDX_W'(WIDX_TIME));
        wr_date = bus_wr && wr_open && (widx == IDX_W'(WIDX_DATE));
        cnt_wr  = wr_time || wr_date;
        step    = run_en && tick_1hz && !cnt_wr;
    end

    rtc_cal_advance adv_i (
        .cur_t(time_q), .cur_d(date_q), .step(step), .nxt_t(time_nx), .nxt_d(date_nx)
    );

    // Control register: always writable
    always_ff @(posedge clk) begin
        if (!rst_n)                                     ctrl_q <= 2'b00;
        else if (bus_wr && widx == IDX_W'(WIDX_CTRL))   ctrl_q <= bus_wdata[1:0];
    end

    // Time word: a guarded write beats a tick
    always_ff @(posedge clk) begin
        if (!rst_n)       time_q <= '0;
        else if (wr_time) time_q <= word_to_time(bus_wdata);
        else if (!wr_date) time_q <= time_nx;
    end

    // Date word: a guarded write beats a tick
    always_ff @(posedge clk) begin
        if (!rst_n)        date_q <= '0;
        else if (wr_date)  date_q <= word_to_date(bus_wdata);
        else if (!wr_time) date_q <= date_nx;
    end

    assign time_word = time_to_word(time_q);
    assign date_word = date_to_word(date_q);

    // Read mux; alarm, alarm status and unmapped words read zero
    always_comb begin
        if (widx == IDX_W'(WIDX_TIME))      bus_rdata = time_word;
        else if (widx == IDX_W'(WIDX_DATE)) bus_rdata = date_word;
        else if (widx == IDX_W'(WIDX_CTRL)) bus_rdata = {30'd0, ctrl_q};
        else                                bus_rdata = 32'd0;
    end
endmodule

// File: rtl/rtc_calendar_chk.sv
// Module: assertion checker bound to rtc_calendar. It watches the bus and the
// stored words. It only observes and drives nothing.
module rtc_calendar_chk #(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic [31:0]       time_word,
    input  logic [31:0]       date_word,
    input  logic [1:0]        ctrl_q
);
    localparam logic [31:0] TIME_MASK = 32'h1F1F3F3F;
    logic [ADDR_W-3:0] ix;
    logic              cw;
    assign ix = bus_addr[ADDR_W-1:2];
    assign cw = bus_wr && ctrl_q[1] && (ix == 0 || ix == 1);

    AST_GUARD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ix == 0 && !ctrl_q[1] && !(ctrl_q[0] && tick_1hz)) |=> time_word == $past(time_word)); // R4
    AST_CTRL_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ix == 4) |=> ctrl_q == $past(bus_wdata[1:0])); // R3
    AST_DEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ix == 2 || ix == 5) |-> bus_rdata == 32'd0); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ctrl_q[0] && tick_1hz) && !cw) |=> ($stable(time_word) && $stable(date_word))); // R6
    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[0] && tick_1hz && !cw && time_word[5:0] == 6'd59) |=> time_word[5:0] == 6'd0); // R7
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ctrl_q[1] && ix == 0) |=> (time_word == ($past(bus_wdata) & TIME_MASK) && $stable(date_word))); // R11
endmodule

bind rtc_calendar rtc_calendar_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .time_word(time_word),
    .date_word(date_word), .ctrl_q(ctrl_q)
);

// File: tb/rtc_calendar_tb_top.sv
// Bench: sweeps the calendar boundaries against an arithmetic model of the calendar.
module rtc_calendar_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    int          n_chk = 0;
    int          n_bad = 0;
    logic        done = 1'b0;

    always #10 clk = ~clk;

    rtc_calendar dut_i (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic wr_tick(logic [4:0] a, logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1; tick_1hz = 1'b1;
        @(negedge clk); bus_wr = 1'b0; tick_1hz = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic tick();
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
    endtask

    function automatic logic [31:0] tw(int dy, int h, int m, int s);
        return (32'(dy) << 24) | (32'(h) << 16) | (32'(m) << 8) | 32'(s);
    endfunction

    function automatic logic [31:0] dw(int c, int y, int mo);
        return (32'(c) << 16) | (32'(y) << 8) | 32'(mo);
    endfunction

    function automatic int dim_of(int mo, int full);
        bit leap = ((full % 4 == 0) && (full % 100 != 0)) || (full % 400 == 0);
        if (mo == 2) return leap ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    // Arithmetic calendar: returns {next date word, next time word}
    function automatic logic [63:0] model_next(logic [31:0] t, logic [31:0] d);
        int dy = int'(t[28:24]); int h = int'(t[20:16]); int m = int'(t[13:8]); int s = int'(t[5:0]);
        int c = int'(d[20:16]); int y = int'(d[14:8]); int mo = int'(d[3:0]);
        s++;
        if (s == 60) begin s = 0; m++; end
        if (m == 60) begin m = 0; h++; end
        if (h == 24) begin h = 0; dy++; end
        if (dy > dim_of(mo, c * 100 + y)) begin dy = 1; mo++; end
        if (mo == 13) begin mo = 1; y++; end
        if (y == 100) begin y = 0; c = (c + 1) % 32; end
        return {dw(c, y, mo), tw(dy, h, m, s)};
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, t, d;
        logic [63:0] e;
        int cents[7] = '{19, 20, 20, 20, 21, 24, 19};
        int yrs[7]   = '{0, 0, 24, 23, 0, 0, 99};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R5: reset state of every word
        for (int a = 0; a < 8; a++) begin
            rd(5'(a * 4), r); check("R1", r, 32'd0);
        end
        check("R5 irq", {31'd0, irq_o}, 32'd0);

        // R3: control read-back and masking
        wr(5'h10, 32'hFFFF_FFFF); rd(5'h10, r); check("R3", r, 32'd3);
        wr(5'h10, 32'd1); rd(5'h10, r); check("R3", r, 32'd1);

        // R4: guard closed, run on, no tick: counter writes dropped
        wr(5'h00, 32'h0A0B_0C0D); rd(5'h00, r); check("R4 time", r, 32'd0);
        wr(5'h04, 32'h0014_1803); rd(5'h04, r); check("R4 date", r, 32'd0);

        // R2: whole-word replace, unused bits zero
        wr(5'h10, 32'd2);
        wr(5'h00, 32'hFFFF_FFFF); rd(5'h00, r); check("R2 time", r, 32'h1F1F_3F3F);
        wr(5'h04, 32'hFFFF_FFFF); rd(5'h04, r); check("R2 date", r, 32'h001F_7F0F);
        wr(5'h00, tw(7, 8, 9, 10)); rd(5'h00, r); check("R2 time", r, 32'h0708_090A);

        // R5: dead words ignore writes and read zero
        wr(5'h08, 32'hFFFF_FFFF); rd(5'h08, r); check("R5 alarm", r, 32'd0);
        wr(5'h14, 32'hFFFF_FFFF); rd(5'h14, r); check("R5 status", r, 32'd0);
        wr(5'h18, 32'hFFFF_FFFF); rd(5'h18, r); check("R5 unmapped", r, 32'd0);
        rd(5'h00, r); check("R5 time kept", r, 32'h0708_090A);
        rd(5'h10, r); check("R5 ctrl kept", r, 32'd2);
        check("R5 irq", {31'd0, irq_o}, 32'd0);

        // R6: run off, ticks hold the time
        repeat (3) tick();
        rd(5'h00, r); check("R6 hold", r, 32'h0708_090A);

        // R6/R7: run of 130 ticks across minute and hour edges
        wr(5'h04, dw(20, 23, 3)); wr(5'h00, tw(5, 0, 58, 50));
        wr(5'h10, 32'd3);
        t = tw(5, 0, 58, 50); d = dw(20, 23, 3);
        for (int i = 0; i < 130; i++) begin
            tick(); e = model_next(t, d); t = e[31:0]; d = e[63:32];
            rd(5'h00, r); check("R7 run", r, t);
        end
        wr(5'h00, tw(5, 23, 59, 59)); tick();
        rd(5'h00, r); check("R7 midnight", r, tw(6, 0, 0, 0));

        // R8/R9/R10: month-end sweep over years chosen for the leap rule
        for (int k = 0; k < 7; k++) begin
            for (int mo = 1; mo <= 12; mo++) begin
                for (int back = 0; back < 2; back++) begin
                    int dm = dim_of(mo, cents[k] * 100 + yrs[k]);
                    d = dw(cents[k], yrs[k], mo); t = tw(dm - back, 23, 59, 59);
                    wr(5'h04, d); wr(5'h00, t); tick();
                    e = model_next(t, d);
                    rd(5'h00, r); check(mo == 2 ? "R9 time" : "R8 time", r, e[31:0]);
                    rd(5'h04, r); check(mo == 12 ? "R10 date" : "R8 date", r, e[63:32]);
                end
            end
        end
        wr(5'h04, dw(19, 99, 12)); wr(5'h00, tw(31, 23, 59, 59)); tick();
        rd(5'h04, r); check("R10 century", r, dw(20, 0, 1));

        // R9: day-by-day walk through 2024
        d = dw(20, 24, 1); t = tw(1, 23, 59, 59);
        wr(5'h04, d); wr(5'h00, t);
        for (int i = 0; i < 366; i++) begin
            tick(); e = model_next(t, d); d = e[63:32];
            rd(5'h04, r); check("R9 walk", r, d);
            t = tw(int'(e[28:24]), 23, 59, 59); wr(5'h00, t);
        end
        check("R9 walk end", d, dw(20, 25, 1));

        // R11: write colliding with tick wins, tick lost
        wr(5'h04, dw(20, 23, 6)); wr(5'h00, tw(30, 23, 59, 59));
        wr_tick(5'h00, tw(30, 23, 59, 50));
        rd(5'h00, r); check("R11 time", r, tw(30, 23, 59, 50));
        rd(5'h04, r); check("R11 date", r, dw(20, 23, 6));
        wr(5'h00, tw(30, 23, 59, 59));
        wr_tick(5'h04, dw(21, 1, 2));
        rd(5'h00, r); check("R11 no tick", r, tw(30, 23, 59, 59));
        rd(5'h04, r); check("R11 date wr", r, dw(21, 1, 2));

        // R4: guard closed while running, write with tick advances normally
        wr(5'h10, 32'd1);
        wr_tick(5'h00, 32'd0);
        rd(5'h00, r); check("R4 locked tick", r, tw(1, 0, 0, 0));
        rd(5'h04, r); check("R4 locked date", r, dw(21, 1, 3));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule